// File: doc/BRIEF.md
# Glitch-free two-clock selector

This block chooses which of two unrelated clocks reaches a single clock output, and changes its choice without ever producing a shortened high or low pulse. Each input has its own select, its own enable and its own no-wait control. An input becomes a candidate only when both its select and its enable are high. A change of candidate is handed over in two halves. The clock that currently drives the output keeps driving it until its own falling edge, and the output then stays low. The incoming clock takes over at its own falling edge, so the first pulse it delivers is a full pulse.

Each input owns a falling-edge synchronizer chain in its own clock domain. A chain captures "this input is wanted and the other input has let go". The last stage of the chain gates the clock, and it only changes while that clock is low. A parameter selects between two select schemes. In the two-line scheme each input has its own select line. In the one-line scheme a single select line picks input 1 when high and input 0 when low. The no-wait control lets the block drop an input without waiting for its falling edge, which is how the block escapes a clock that has stopped.

Top module: `gf_clock_mux`

## Requirements
- R1: While `rst` is high, `clk_out` is low. Reset hands ownership to input 0, so after release `clk_out` follows `clk_in0` whenever input 0 is a candidate.
- R2: Input i is a candidate only when `pick<i>` and `en<i>` are both 1. When neither input is a candidate, `clk_out` parks low and has no rising edges.
- R3: `clk_out` never shows a high or low pulse shorter than the shorter half-period of the two inputs, and the two inputs never gate the output at the same time. On a handover, the old clock is cut off at its falling edge and the new clock starts at its own falling edge.
- R4: After the candidate changes, `clk_out` runs at the new input's period within (2*SYNC_STAGES+1) periods of the slower input clock.
- R5: With SEL_MODE = SEL_PAIR, when both inputs are candidates, input 0 drives the output.
- R6: When `nowait<i>` is high and input i is not a candidate, input i releases at once without waiting for its falling edge. Without it, a stopped clock that currently owns the output keeps `clk_out` low and blocks the handover.
- R7: With SEL_MODE = SEL_SINGLE, `pick0` = 0 selects input 0 and `pick0` = 1 selects input 1, each qualified by its enable. `pick1` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset, asserts asynchronously; forces output low and gives ownership to input 0 |
| clk_in0 | input | 1 | Clock input 0 |
| clk_in1 | input | 1 | Clock input 1 |
| pick0 | input | 1 | Select for input 0 (in single mode, the shared select) |
| pick1 | input | 1 | Select for input 1 (unused in single mode) |
| en0 | input | 1 | Enable qualifying input 0 |
| en1 | input | 1 | Enable qualifying input 1 |
| nowait0 | input | 1 | Release input 0 without waiting for its falling edge |
| nowait1 | input | 1 | Release input 1 without waiting for its falling edge |
| clk_out | output | 1 | Selected, glitch-free clock |

## Verification
The bench builds two copies of the block, both with SYNC_STAGES = 2. One copy uses the two-line select scheme. The other uses the one-line scheme, which exercises the unused second select. The input clocks run at 4 ns against 7 ns, and later at 4 ns against 10.6 ns. With these ratios, handovers between periods that do and do not divide evenly can be observed. The latency window stays short enough for dozens of random handovers. Stopping input 0 entirely brings the blocked-handover case and its no-wait escape within reach.

// File: rtl/gfcm_pkg.sv
package gfcm_pkg;

  typedef enum logic {
    SEL_PAIR   = 1'b0,
    SEL_SINGLE = 1'b1
  } sel_mode_e;

  // Returns {want1, want0}; the two bits are never both set.
  function automatic logic [1:0] candidates(input sel_mode_e mode,
                                            input logic p0, input logic p1,
                                            input logic e0, input logic e1);
    logic w0, w1;
    if (mode == SEL_SINGLE) begin
      w0 = ~p0 & e0;
      w1 = p0 & e1;
    end else begin
      w0 = p0 & e0;
      w1 = p1 & e1 & ~w0;   // input 0 wins a tie
    end
    return {w1, w0};
  endfunction

endpackage

// File: rtl/gfcm_fsync.sv
module gfcm_fsync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES < 2) begin : g_bad
      $error("gfcm_fsync needs at least two stages");
    end
  endgenerate

  // Falling-edge chain: q only moves while clk is low.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) pipe <= {STAGES{INIT}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gfcm_branch.sv
module gfcm_branch #(
  parameter int SYNC_STAGES  = 2,
  parameter bit OWN_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic nowait,
  input  logic peer_gate,
  output logic gate
);
  logic req;
  logic owned;

  // Ask for the output only once the other side has let go.
  assign req = want & ~peer_gate;

  gfcm_fsync #(
    .STAGES(SYNC_STAGES),
    .INIT  (OWN_AT_RESET)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (req),
    .q  (owned)
  );

  // nowait lets an unwanted input drop out without its own edge.
  assign gate = owned & (want | ~nowait);

  // R3: ownership is only taken while the other side is idle.
  assert_take_when_peer_idle_R3: assert property (
    @(negedge clk) disable iff (rst) $rose(owned) |-> !peer_gate
  );

  // R2: ownership is only given up when this input is no candidate.
  assert_release_only_unwanted_R2: assert property (
    @(negedge clk) disable iff (rst) $fell(owned) |-> !want
  );
endmodule

// File: rtl/gf_clock_mux.sv
module gf_clock_mux
  import gfcm_pkg::*;
#(
  parameter int        SYNC_STAGES = 2,
  parameter sel_mode_e SEL_MODE    = SEL_PAIR
) (
  input  logic rst,
  input  logic clk_in0,
  input  logic clk_in1,
  input  logic pick0,
  input  logic pick1,
  input  logic en0,
  input  logic en1,
  input  logic nowait0,
  input  logic nowait1,
  output logic clk_out
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] clk_vec;
  logic [NUM_IN-1:0] nowait_vec;
  logic [NUM_IN-1:0] want;
  logic [NUM_IN-1:0] gate;

  assign clk_vec    = {clk_in1, clk_in0};
  assign nowait_vec = {nowait1, nowait0};
  assign want       = candidates(SEL_MODE, pick0, pick1, en0, en1);

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_br
      gfcm_branch #(
        .SYNC_STAGES (SYNC_STAGES),
        .OWN_AT_RESET(g == 0)
      ) u_branch (
        .clk      (clk_vec[g]),
        .rst      (rst),
        .want     (want[g]),
        .nowait   (nowait_vec[g]),
        .peer_gate(gate[NUM_IN-1-g]),
        .gate     (gate[g])
      );
    end
  endgenerate

  assign clk_out = ~rst & (|(clk_vec & gate));

  // R3: the two inputs never gate the output together.
  assert_single_owner_c0_R3: assert property (
    @(negedge clk_in0) disable iff (rst) !(gate[0] && gate[1])
  );
  assert_single_owner_c1_R3: assert property (
    @(negedge clk_in1) disable iff (rst) !(gate[0] && gate[1])
  );
endmodule

// File: tb/gf_clock_mux_tb_top.sv
`timescale 1ns/1ps
module gf_clock_mux_tb_top;
  localparam int      SYNC  = 2;
  localparam realtime HALF0 = 2.0;   // 250 MHz

  logic rst = 1'b1, clk0 = 1'b0, clk1 = 1'b0;
  bit   run0 = 1'b1;
  realtime half1 = 3.5;
  logic pick0 = 1'b1, pick1 = 1'b0, en0 = 1'b1, en1 = 1'b1;
  logic nw0 = 1'b0, nw1 = 1'b0;
  logic s_sel = 1'b0, s_aux = 1'b0;
  logic clk_out, clk_single;

  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0, done = 1'b0;
  realtime last_edge = -1.0;

  gf_clock_mux #(.SYNC_STAGES(SYNC), .SEL_MODE(gfcm_pkg::SEL_PAIR)) dut_i (
    .rst(rst), .clk_in0(clk0), .clk_in1(clk1), .pick0(pick0), .pick1(pick1),
    .en0(en0), .en1(en1), .nowait0(nw0), .nowait1(nw1), .clk_out(clk_out));

  gf_clock_mux #(.SYNC_STAGES(SYNC), .SEL_MODE(gfcm_pkg::SEL_SINGLE)) dut_single_i (
    .rst(rst), .clk_in0(clk0), .clk_in1(clk1), .pick0(s_sel), .pick1(s_aux),
    .en0(1'b1), .en1(1'b1), .nowait0(1'b0), .nowait1(1'b0), .clk_out(clk_single));

  always begin #(HALF0); clk0 = run0 ? ~clk0 : 1'b0; end
  always begin #(half1); clk1 = ~clk1; end

  // R3: pulse-width monitor on every output edge.
  always @(clk_out) begin
    if (mon_en && last_edge >= 0.0) begin
      n_chk++;
      if ($realtime - last_edge < HALF0 - 0.05) begin
        n_fail++;
        $display("FAIL R3 pulse width actual %0.3f ns expected >= %0.3f ns",
                 $realtime - last_edge, HALF0);
      end
    end
    last_edge = $realtime;
  end

  function automatic realtime slow_period();
    return (2.0 * half1 > 2.0 * HALF0) ? 2.0 * half1 : 2.0 * HALF0;
  endfunction

  task automatic observe(input bit single, output int rises,
                         output realtime p_first, output realtime p_last,
                         output logic lvl);
    realtime t_prev = -1.0;
    logic prev = single ? clk_single : clk_out;
    int steps = int'(8.0 * slow_period() * 10.0);
    rises = 0; p_first = 0.0; p_last = 0.0;
    for (int k = 0; k < steps; k++) begin
      logic cur;
      #0.1;
      cur = single ? clk_single : clk_out;
      if (cur && !prev) begin
        rises++;
        if (t_prev >= 0.0) begin
          if (p_first == 0.0) p_first = $realtime - t_prev;
          p_last = $realtime - t_prev;
        end
        t_prev = $realtime;
      end
      prev = cur;
    end
    lvl = single ? clk_single : clk_out;
  endtask

  // Waits the R4 latency bound, then demands a clean run at period exp.
  task automatic expect_period(input string tag, input bit single, input realtime exp);
    int r; realtime pf, pl; logic lv;
    #((2 * SYNC + 1) * slow_period() + 1.0);
    observe(single, r, pf, pl, lv);
    n_chk++;
    if (r < 3 || pf < exp - 0.15 || pf > exp + 0.15 || pl < exp - 0.15 || pl > exp + 0.15) begin
      n_fail++;
      $display("FAIL %s period actual first=%0.2f last=%0.2f rises=%0d expected %0.2f",
               tag, pf, pl, r, exp);
    end
  endtask

  task automatic expect_silent(input string tag, input bit single);
    int r; realtime pf, pl; logic lv;
    observe(single, r, pf, pl, lv);
    n_chk++;
    if (r != 0 || lv !== 1'b0) begin
      n_fail++;
      $display("FAIL %s parked output actual rises=%0d level=%b expected rises=0 level=0",
               tag, r, lv);
    end
  endtask

  task automatic release_reset();
    @(negedge clk0);
    #0.5 rst = 1'b0;
    #1.0 mon_en = 1'b1;
  endtask

  initial begin
    #(200000 * 4.0);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=still running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset parks the output, then input 0 takes over.
    #3.0;
    expect_silent("R1", 1'b0);
    release_reset();
    expect_period("R1", 1'b0, 2.0 * HALF0);

    // R2: no candidate parks low; a disabled input is no candidate.
    pick0 = 1'b0;
    #((2 * SYNC + 1) * slow_period() + 1.0);
    expect_silent("R2", 1'b0);
    en1 = 1'b0; pick1 = 1'b1;
    #20.0;
    expect_silent("R2", 1'b0);
    en1 = 1'b1;
    expect_period("R2", 1'b0, 2.0 * half1);

    // R5: both candidates, input 0 wins.
    pick0 = 1'b1;
    expect_period("R5", 1'b0, 2.0 * HALF0);

    // R4 / R3: random handovers with two clock ratios.
    for (int phase = 0; phase < 2; phase++) begin
      for (int k = 0; k < 14; k++) begin
        bit s = 1'($urandom % 2);
        #($urandom % 7);
        pick0 = ~s; pick1 = s;
        expect_period("R4", 1'b0, s ? 2.0 * half1 : 2.0 * HALF0);
      end
      pick0 = 1'b1; pick1 = 1'b0;
      expect_period("R4", 1'b0, 2.0 * HALF0);
      half1 = 5.3;
    end

    // R7: single-select scheme; pick1 has no effect.
    s_sel = 1'b0;
    expect_period("R7", 1'b1, 2.0 * HALF0);
    s_aux = 1'b1;
    expect_period("R7", 1'b1, 2.0 * HALF0);
    s_sel = 1'b1;
    expect_period("R7", 1'b1, 2.0 * half1);
    s_aux = 1'b0;
    expect_period("R7", 1'b1, 2.0 * half1);

    // R6: a stopped owner blocks the handover unless nowait is set.
    run0 = 1'b0;
    #10.0;
    pick0 = 1'b0; pick1 = 1'b1;
    #((2 * SYNC + 1) * slow_period() + 1.0);
    expect_silent("R6", 1'b0);
    nw0 = 1'b1;
    expect_period("R6", 1'b0, 2.0 * half1);
    run0 = 1'b1;
    #30.0;
    nw0 = 1'b0;
    expect_period("R6", 1'b0, 2.0 * half1);

    // R1: reset in mid-run returns ownership to input 0.
    mon_en = 1'b0;
    pick0 = 1'b1; pick1 = 1'b0;
    rst = 1'b1;
    #3.0;
    expect_silent("R1", 1'b0);
    release_reset();
    expect_period("R1", 1'b0, 2.0 * HALF0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule